// File: doc/BRIEF.md
# Line Alarm Persistence Qualifier

This block turns raw, frame-by-frame line alarm indications into stable status bits. It is fed once per received frame with the K2 overhead byte and a strobe that marks the byte as valid. From the three low-order bits of that byte it decides, for each frame, whether three alarm conditions are present: line alarm indication signal (AIS), line far-end receive failure (FERF) and line remote defect indication (RDI). Each raw indication then passes through its own persistence filter before it can change the reported status.

Each filter has an 8-bit threshold register. The high nibble is the number of back-to-back frames that must show the condition before the status bit is set. The low nibble is the number of back-to-back frames that must be free of the condition before the status bit is cleared. Software programs these registers over a simple write-only bus. When any status bit changes, the block flags that alarm for one clock and raises a combined interrupt pulse.

Top module: `line_alarm_filter`

## Requirements
- R1: The AIS condition is present in a frame exactly when k2_byte[2:0] == 3'b111. Any other value of that field counts as a frame without AIS.
- R2: The FERF and RDI conditions (alarm indices 1 and 2) are both present in a frame exactly when k2_byte[2:0] == 3'b110. Any other value counts as a frame without them.
- R3: A clear status bit sets on the valid frame that completes a run of consecutive frames with the condition whose length equals the high nibble (bits [7:4]) of that alarm's threshold register.
- R4: A set status bit clears on the valid frame that completes a run of consecutive frames without the condition whose length equals the low nibble (bits [3:0]) of that alarm's threshold register.
- R5: A valid frame that agrees with the current status bit restarts the run count toward a change from zero. Every change of the status bit also restarts that count.
- R6: A threshold nibble of 0 behaves like 1, so the status acts on the first qualifying frame.
- R7: Reset clears every status bit, every change flag and the interrupt, and loads all three threshold registers with 8'h33.
- R8: alarm_chg[i] is high for exactly the one clock after the edge where alarm_status[i] changes. alarm_irq is the OR of all bits of alarm_chg.
- R9: A write with wr_en high loads wr_data into the threshold register of AIS at address 0x016, of FERF at 0x017 and of RDI at 0x018. Writes to any other address change no threshold.
- R10: Clocks with frame_valid low change neither the status bits nor the run counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| frame_valid | input | 1 | Marks k2_byte as one frame's K2 byte; one clock per frame |
| k2_byte | input | 8 | Received K2 overhead byte |
| wr_en | input | 1 | Threshold register write strobe |
| wr_addr | input | ADDR_W (8) | Threshold register address |
| wr_data | input | 8 | Threshold value: high nibble is the set count, low nibble is the clear count |
| alarm_status | output | 3 | Qualified status: bit 0 AIS, bit 1 FERF, bit 2 RDI |
| alarm_chg | output | 3 | One-clock flag per alarm marking a change of its status bit |
| alarm_irq | output | 1 | One-clock interrupt pulse on any status change |

## Verification
The assertions assume that frame_valid is never X once reset is released. They also assume that k2_byte is stable whenever frame_valid is high, since the status may only move in the direction that the sampled frame supports. The stimulus drives every input at the falling edge and keeps frame_valid high for a single clock per frame. It runs burst patterns of 111, 110 and other codes of growing length, swept over every set and clear nibble from 0 to 15. Between bursts it inserts idle clocks that carry an alarm code with frame_valid low, and it writes to addresses just outside the register window.

// File: rtl/line_alarm_pkg.sv
package line_alarm_pkg;

  localparam int unsigned NIB_W     = 4;
  localparam int unsigned THR_W     = 2 * NIB_W;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned NUM_ALARM = 3;

  typedef enum logic [1:0] {
    ALM_AIS  = 2'd0,
    ALM_FERF = 2'd1,
    ALM_RDI  = 2'd2
  } alarm_idx_e;

  localparam logic [CODE_W-1:0] CODE_AIS    = 3'b111;
  localparam logic [CODE_W-1:0] CODE_REMOTE = 3'b110;

  function automatic logic [CODE_W-1:0] alarm_code(input int unsigned idx);
    return (idx == int'(ALM_AIS)) ? CODE_AIS : CODE_REMOTE;
  endfunction

endpackage

// File: rtl/lafq_cond_detect.sv
module lafq_cond_detect
  import line_alarm_pkg::*;
#(
  parameter int unsigned NUM = NUM_ALARM
) (
  input  logic [7:0]     k2_byte,
  output logic [NUM-1:0] cond
);

  logic [CODE_W-1:0] code_field;

  assign code_field = k2_byte[CODE_W-1:0];

  for (genvar gi = 0; gi < NUM; gi++) begin : g_cond
    localparam logic [CODE_W-1:0] PATTERN = alarm_code(gi);
    assign cond[gi] = (code_field == PATTERN);
  end

endmodule

// File: rtl/lafq_thresh_regs.sv
module lafq_thresh_regs
  import line_alarm_pkg::*;
#(
  parameter int unsigned NUM       = NUM_ALARM,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h16,
  parameter logic [THR_W-1:0]  RST_VAL   = 8'h33
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [THR_W-1:0]         wr_data,
  output logic [NUM-1:0][THR_W-1:0] thr
);

  for (genvar gi = 0; gi < NUM; gi++) begin : g_reg
    localparam logic [ADDR_W-1:0] MY_ADDR = BASE_ADDR + ADDR_W'(gi);
    logic             hit;
    logic [THR_W-1:0] thr_q;
    logic [THR_W-1:0] thr_d;

    assign hit = wr_en && (wr_addr == MY_ADDR);

    always_comb begin
      thr_d = thr_q;
      if (hit) thr_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q <= RST_VAL;
      else        thr_q <= thr_d;
    end

    assign thr[gi] = thr_q;
  end

endmodule

// File: rtl/lafq_persist.sv
module lafq_persist #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_valid,
  input  logic             cond,
  input  logic [CNT_W-1:0] set_thr,
  input  logic [CNT_W-1:0] clr_thr,
  output logic             status,
  output logic             chg
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             status_q, status_d;
  logic             chg_q, chg_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [CNT_W-1:0] eff_set, eff_clr, target, run_inc;

  always_comb begin
    eff_set = (set_thr == '0) ? CNT_ONE : set_thr;
    eff_clr = (clr_thr == '0) ? CNT_ONE : clr_thr;
    target  = status_q ? eff_clr : eff_set;
    run_inc = (run_q == CNT_MAX) ? run_q : run_q + CNT_ONE;
  end

  always_comb begin
    status_d = status_q;
    run_d    = run_q;
    chg_d    = 1'b0;
    if (frame_valid) begin
      if (cond == status_q) begin
        run_d = '0;
      end else if (run_inc >= target) begin
        status_d = ~status_q;
        run_d    = '0;
        chg_d    = 1'b1;
      end else begin
        run_d = run_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
      chg_q    <= 1'b0;
      run_q    <= '0;
    end else begin
      status_q <= status_d;
      chg_q    <= chg_d;
      run_q    <= run_d;
    end
  end

  assign status = status_q;
  assign chg    = chg_q;

endmodule

// File: rtl/line_alarm_filter.sv
module line_alarm_filter
  import line_alarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h16,
  parameter logic [THR_W-1:0]  THR_RST   = 8'h33
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_valid,
  input  logic [7:0]           k2_byte,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [THR_W-1:0]     wr_data,
  output logic [NUM_ALARM-1:0] alarm_status,
  output logic [NUM_ALARM-1:0] alarm_chg,
  output logic                 alarm_irq
);

  logic [NUM_ALARM-1:0]            cond;
  logic [NUM_ALARM-1:0][THR_W-1:0] thr;

  lafq_cond_detect #(.NUM(NUM_ALARM)) u_detect (
    .k2_byte (k2_byte),
    .cond    (cond)
  );

  lafq_thresh_regs #(
    .NUM       (NUM_ALARM),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .RST_VAL   (THR_RST)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .thr     (thr)
  );

  for (genvar gi = 0; gi < NUM_ALARM; gi++) begin : g_filt
    lafq_persist #(.CNT_W(NIB_W)) u_persist (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_valid (frame_valid),
      .cond        (cond[gi]),
      .set_thr     (thr[gi][THR_W-1:NIB_W]),
      .clr_thr     (thr[gi][NIB_W-1:0]),
      .status      (alarm_status[gi]),
      .chg         (alarm_chg[gi])
    );
  end

  assign alarm_irq = |alarm_chg;

endmodule

// File: rtl/line_alarm_filter_chk.sv
module line_alarm_filter_chk
  import line_alarm_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 frame_valid,
  input logic [7:0]           k2_byte,
  input logic [NUM_ALARM-1:0] alarm_status,
  input logic [NUM_ALARM-1:0] alarm_chg,
  input logic                 alarm_irq
);

  assert_ais_no_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && k2_byte[2:0] != 3'b111) |=> !$rose(alarm_status[0]));

  assert_ais_no_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && k2_byte[2:0] == 3'b111) |=> !$fell(alarm_status[0]));

  for (genvar gi = 1; gi < NUM_ALARM; gi++) begin : g_remote
    assert_remote_no_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && k2_byte[2:0] != 3'b110) |=> !$rose(alarm_status[gi]));

    assert_remote_no_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && k2_byte[2:0] == 3'b110) |=> !$fell(alarm_status[gi]));
  end

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> $stable(alarm_status));

  assert_flag_tracks_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_chg == (alarm_status ^ $past(alarm_status)));

  assert_irq_any_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_irq == (alarm_chg != '0));

endmodule

bind line_alarm_filter line_alarm_filter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_valid  (frame_valid),
  .k2_byte      (k2_byte),
  .alarm_status (alarm_status),
  .alarm_chg    (alarm_chg),
  .alarm_irq    (alarm_irq)
);

// File: tb/line_alarm_filter_test.sv
module line_alarm_filter_test;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic       clk;
  logic       rst_n;
  logic       frame_valid;
  logic [7:0] k2_byte;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic [2:0] alarm_status;
  logic [2:0] alarm_chg;
  logic       alarm_irq;

  int checks;
  int errors;
  bit done;

  int m_set[3];
  int m_clr[3];
  int m_run[3];
  bit m_st[3];
  bit m_chg[3];

  line_alarm_filter uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_valid  (frame_valid),
    .k2_byte      (k2_byte),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .alarm_status (alarm_status),
    .alarm_chg    (alarm_chg),
    .alarm_irq    (alarm_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  task automatic compare_outputs(input string req);
    int exp_st;
    int exp_chg;
    exp_st  = {29'd0, m_st[2], m_st[1], m_st[0]};
    exp_chg = {29'd0, m_chg[2], m_chg[1], m_chg[0]};
    check(req, int'(alarm_status), exp_st);
    check("R8 change flags", int'(alarm_chg), exp_chg);
    check("R8 interrupt", int'(alarm_irq), int'(exp_chg != 0));
  endtask

  // drive one frame at a falling edge, compare after the capturing edge
  task automatic frame(input logic [7:0] k2, input string req);
    bit c;
    frame_valid = 1'b1;
    k2_byte     = k2;
    @(negedge clk);
    frame_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      c = (i == 0) ? (k2[2:0] == 3'b111) : (k2[2:0] == 3'b110);
      m_chg[i] = 1'b0;
      if (c == m_st[i]) begin
        m_run[i] = 0;
      end else begin
        m_run[i] = (m_run[i] >= 15) ? 15 : m_run[i] + 1;
        if (m_run[i] >= eff(m_st[i] ? m_clr[i] : m_set[i])) begin
          m_st[i]  = ~m_st[i];
          m_chg[i] = 1'b1;
          m_run[i] = 0;
        end
      end
    end
    compare_outputs(req);
  endtask

  task automatic idle(input int n, input logic [7:0] k2);
    k2_byte = k2;
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) m_chg[i] = 1'b0;
      compare_outputs("R10 idle clock");
    end
  endtask

  task automatic write_reg(input logic [7:0] addr, input logic [7:0] data);
    wr_en   = 1'b1;
    wr_addr = addr;
    wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
    if (addr >= 8'h16 && addr <= 8'h18) begin
      m_set[addr - 8'h16] = int'(data[7:4]);
      m_clr[addr - 8'h16] = int'(data[3:0]);
    end
    for (int i = 0; i < 3; i++) m_chg[i] = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    checks      = 0;
    errors      = 0;
    done        = 1'b0;
    rst_n       = 1'b0;
    frame_valid = 1'b0;
    k2_byte     = 8'h00;
    wr_en       = 1'b0;
    wr_addr     = 8'h00;
    wr_data     = 8'h00;
    for (int i = 0; i < 3; i++) begin
      m_set[i] = 3; m_clr[i] = 3; m_run[i] = 0; m_st[i] = 0; m_chg[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: reset state
    check("R7 status after reset", int'(alarm_status), 0);
    check("R7 flags after reset", int'(alarm_chg), 0);
    check("R7 irq after reset", int'(alarm_irq), 0);

    // R7: default thresholds of 3 frames each way
    frame(8'h07, "R7 default set count");
    frame(8'h07, "R7 default set count");
    frame(8'h07, "R7 default set count");
    check("R7 AIS set on third frame", int'(alarm_status[0]), 1);
    frame(8'h06, "R7 default clear count");
    frame(8'h06, "R7 default clear count");
    frame(8'h06, "R7 default clear count");
    check("R7 remote alarms set on third frame", int'(alarm_status[2:1]), 3);
    frame(8'h00, "R7 default clear count");
    frame(8'h00, "R7 default clear count");
    frame(8'h00, "R7 default clear count");
    check("R7 all clear after three quiet frames", int'(alarm_status), 0);

    // R9: writes outside the window are ignored
    write_reg(8'h15, 8'h11);
    write_reg(8'h19, 8'h11);
    frame(8'hF7, "R9 ignored write keeps AIS set count");
    frame(8'hF7, "R9 ignored write keeps AIS set count");
    check("R9 AIS still needs three frames", int'(alarm_status[0]), 0);
    frame(8'hF7, "R9 ignored write keeps AIS set count");
    frame(8'h00, "R9");
    frame(8'h00, "R9");
    frame(8'h00, "R9");

    // sweep every set and clear nibble
    for (int s = 0; s < 16; s++) begin
      write_reg(8'h16, 8'((s << 4) | (15 - s)));
      write_reg(8'h17, 8'(((15 - s) << 4) | s));
      write_reg(8'h18, 8'((s << 4) | s));
      for (int len = 1; len <= 16; len++) begin
        for (int f = 0; f < len; f++) frame(8'hA7, "R1 R3 R4 R5 R6");
        idle(1, 8'h07);
        for (int f = 0; f < len; f++) frame(8'h5E, "R2 R3 R4 R5 R6");
        idle(1, 8'h06);
        for (int f = 0; f < len; f++) frame(8'(len * 8 + 3), "R1 R2 R4 R5 R6");
      end
      for (int f = 0; f < 16; f++) frame(8'h00, "R4 R6");
    end

    // R10: long idle stretches carrying alarm codes
    write_reg(8'h16, 8'h22);
    frame(8'h07, "R10");
    idle(5, 8'h00);
    frame(8'h07, "R10 run kept across idle");
    check("R10 AIS set after split run", int'(alarm_status[0]), 1);
    idle(5, 8'h07);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule